// File: doc/BRIEF.md
# Lock Elision Conflict Monitor

This block follows one critical section that a core runs without taking its lock. When the section opens, the block asks for a register checkpoint. It then marks every cache block the core reads or writes. It holds the core's stores in a private buffer, so other cores cannot see them. It also watches coherence requests coming from other cores. If another core tries to invalidate a marked block, or to take exclusive ownership of it, the speculation has failed. In that case the block throws away the buffered stores, clears its marks and asks for a rollback. The speculation also fails when the buffer or the mark table has no room for a new block.

When the section closes cleanly, the buffered stores are written out one per cycle. While they drain, the block holds back responses to snooped requests. Outside observers therefore see every store or none of them. Each store that takes a new buffer slot also raises an ownership request for its block. This lets the coherence engine fetch the block in exclusive state ahead of the commit.

Top module: `elision_monitor`

## Requirements
- R1: After reset the block is idle. `spec_active`, `ckpt_req`, `rollback`, `own_req_valid`, `wr_valid` and `snp_hold` are all low.
- R2: `sec_begin` while idle starts elision. `ckpt_req` is high for exactly the one cycle after that edge, and `spec_active` goes high in the same cycle. `sec_begin` has no effect while elision or a commit is under way.
- R3: During elision, a store to a block with no buffer entry takes the next free entry. The cycle after, `own_req_valid` is high for one cycle with `own_req_addr` set to that block. No buffered store appears on `wr_valid` before the commit.
- R4: During elision, a store to a block that already has a buffer entry replaces that entry's data. It uses no new entry and raises no ownership request.
- R5: Every load or store made during elision marks its block. A snoop of kind invalidate (`snp_kind` = 2) that hits a marked block aborts the speculation.
- R6: A snoop of kind exclusive request (`snp_kind` = 3) that hits a marked block aborts the speculation.
- R7: A snoop of kind read (`snp_kind` = 1) has no effect. A snoop of kind 2 or 3 to an unmarked block has no effect.
- R8: A store that needs a new buffer entry while all `WB_DEPTH` entries are in use aborts. A store that merges into an existing entry does not abort, even when the buffer is full.
- R9: A load or store to an unmarked block while all `MARK_DEPTH` mark entries are in use aborts. An access to a block that is already marked does not abort.
- R10: On abort, `rollback` is high for exactly the following cycle, and the block returns to idle. Buffered stores are discarded and all marks are cleared. An abort has priority over a `sec_end` in the same cycle.
- R11: `sec_end` during elision with at least one buffered store starts a commit in the next cycle. The commit puts one store per cycle on `wr_valid`/`wr_addr`/`wr_data`, in the order the entries were taken, each with its latest data. `snp_hold` is high in exactly those cycles, and snoops seen during the drain cause no abort.
- R12: `sec_end` during elision with an empty buffer returns the block straight to idle. No write and no `snp_hold` result.
- R13: Loads, stores, snoops and `sec_end` seen while idle have no effect. They create no marks, no buffer entries and no ownership requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_begin | input | 1 | Critical section start marker |
| sec_end | input | 1 | Critical section end marker |
| req_valid | input | 1 | Core load/store request valid |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Cache-block address of the request |
| req_data | input | DATA_W | Store data |
| snp_valid | input | 1 | Snooped request from another core is valid |
| snp_kind | input | 2 | 1 read, 2 invalidate, 3 exclusive request |
| snp_addr | input | ADDR_W | Block address of the snooped request |
| spec_active | output | 1 | Elision in progress |
| ckpt_req | output | 1 | One-cycle register checkpoint request |
| rollback | output | 1 | One-cycle abort and restore request |
| own_req_valid | output | 1 | Exclusive ownership request valid |
| own_req_addr | output | ADDR_W | Block to own |
| wr_valid | output | 1 | Commit write valid |
| wr_addr | output | ADDR_W | Commit write block address |
| wr_data | output | DATA_W | Commit write data |
| snp_hold | output | 1 | Hold snoop responses while the commit drains |

## Verification
The bench builds the block with a 4-entry write buffer and an 8-entry mark table. At those sizes, both ways of running out of room can be reached within a few dozen cycles. This covers the abort on a fifth distinct store and on a ninth distinct block. It also covers the case of a merge into a full buffer, which must not abort. With 16-bit addresses and 32-bit data, the drain order and the latest-data replacement can be read directly off the commit port.

// File: rtl/elision_pkg.sv
package elision_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SPEC   = 2'd1,
        ST_COMMIT = 2'd2
    } el_state_e;

    localparam logic [1:0] SNP_READ  = 2'd1;
    localparam logic [1:0] SNP_INVAL = 2'd2;
    localparam logic [1:0] SNP_EXCL  = 2'd3;

    typedef struct packed {
        logic snoop_hit;
        logic wb_full;
        logic mark_full;
    } abort_why_t;

    function automatic logic snoop_hostile(input logic [1:0] kind);
        return (kind == SNP_INVAL) || (kind == SNP_EXCL);
    endfunction

endpackage

// File: rtl/elision_mark_table.sv
module elision_mark_table #(
    parameter int ADDR_W = 26,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_hit,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_hit,
    input  logic              ins_en,
    output logic              full
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] tag_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [DEPTH-1:0]  req_match;
    logic [DEPTH-1:0]  snp_match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic live;
        assign live         = CNT_W'(i) < cnt_q;
        assign req_match[i] = live && (tag_q[i] == req_addr);
        assign snp_match[i] = live && (tag_q[i] == snp_addr);
    end

    assign req_hit = |req_match;
    assign snp_hit = |snp_match;
    assign full    = (cnt_q == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (ins_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en && !clr) begin
            tag_q[cnt_q[$clog2(DEPTH)-1:0]] <= req_addr;
        end
    end

    // R9
    mark_room_chk: assert property (@(posedge clk) disable iff (rst)
        ins_en |-> (!full && !req_hit));

endmodule

// File: rtl/elision_wbuf.sv
module elision_wbuf #(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 64,
    parameter int DEPTH  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic [ADDR_W-1:0]        lk_addr,
    output logic                     lk_hit,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     full,
    output logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [DEPTH-1:0]  match;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  slot;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = (CNT_W'(i) < cnt_q) && (addr_q[i] == lk_addr);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign lk_hit  = |match;
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign count   = cnt_q;
    assign slot    = lk_hit ? hit_idx : cnt_q[IDX_W-1:0];
    assign rd_addr = addr_q[rd_idx];
    assign rd_data = data_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (wr_en && !lk_hit) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            addr_q[slot] <= lk_addr;
            data_q[slot] <= wr_data;
        end
    end

    // R8
    wb_alloc_room_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !lk_hit) |-> !full);

    // R4
    wb_merge_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lk_hit && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/elision_monitor.sv
module elision_monitor
    import elision_pkg::*;
#(
    parameter int ADDR_W     = 26,
    parameter int DATA_W     = 64,
    parameter int WB_DEPTH   = 8,
    parameter int MARK_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_begin,
    input  logic              sec_end,
    input  logic              req_valid,
    input  logic              req_is_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              spec_active,
    output logic              ckpt_req,
    output logic              rollback,
    output logic              own_req_valid,
    output logic [ADDR_W-1:0] own_req_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              snp_hold
);
    localparam int WB_CNT_W = $clog2(WB_DEPTH + 1);
    localparam int WB_IDX_W = $clog2(WB_DEPTH);

    el_state_e         state_q, state_d;
    logic [WB_IDX_W-1:0] drain_q;
    logic              ckpt_q, rb_q, own_q;
    logic [ADDR_W-1:0] own_addr_q;

    logic              mk_req_hit, mk_snp_hit, mk_full, mk_ins, mk_clr;
    logic              wb_hit, wb_full, wb_wr, wb_clr;
    logic [WB_CNT_W-1:0] wb_count;
    logic [ADDR_W-1:0] wb_rd_addr;
    logic [DATA_W-1:0] wb_rd_data;

    logic              in_spec, in_commit;
    logic              need_mark, need_slot, abort;
    logic              drain_last, end_empty;
    abort_why_t        why;

    assign in_spec   = (state_q == ST_SPEC);
    assign in_commit = (state_q == ST_COMMIT);

    assign need_mark = req_valid && !mk_req_hit;
    assign need_slot = req_valid && req_is_store && !wb_hit;

    always_comb begin
        why.snoop_hit = snp_valid && snoop_hostile(snp_kind) && mk_snp_hit;
        why.wb_full   = need_slot && wb_full;
        why.mark_full = need_mark && mk_full;
    end

    assign abort      = in_spec && (|why);
    assign mk_ins     = in_spec && need_mark && !abort;
    assign wb_wr      = in_spec && req_valid && req_is_store && !abort;
    assign end_empty  = (wb_count == '0) && !(wb_wr && !wb_hit);
    assign drain_last = (WB_CNT_W'(drain_q) + WB_CNT_W'(1)) == wb_count;

    assign wb_clr = abort || (in_commit && drain_last);
    assign mk_clr = wb_clr || (in_spec && sec_end && end_empty);

    elision_mark_table #(
        .ADDR_W (ADDR_W),
        .DEPTH  (MARK_DEPTH)
    ) u_marks (
        .clk      (clk),
        .rst      (rst),
        .clr      (mk_clr),
        .req_addr (req_addr),
        .req_hit  (mk_req_hit),
        .snp_addr (snp_addr),
        .snp_hit  (mk_snp_hit),
        .ins_en   (mk_ins),
        .full     (mk_full)
    );

    elision_wbuf #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (WB_DEPTH)
    ) u_wbuf (
        .clk     (clk),
        .rst     (rst),
        .clr     (wb_clr),
        .lk_addr (req_addr),
        .lk_hit  (wb_hit),
        .wr_en   (wb_wr),
        .wr_data (req_data),
        .full    (wb_full),
        .count   (wb_count),
        .rd_idx  (drain_q),
        .rd_addr (wb_rd_addr),
        .rd_data (wb_rd_data)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sec_begin) state_d = ST_SPEC;
            end
            ST_SPEC: begin
                if (abort)             state_d = ST_IDLE;
                else if (sec_end)      state_d = end_empty ? ST_IDLE : ST_COMMIT;
            end
            ST_COMMIT: begin
                if (drain_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            drain_q    <= '0;
            ckpt_q     <= 1'b0;
            rb_q       <= 1'b0;
            own_q      <= 1'b0;
            own_addr_q <= '0;
        end else begin
            state_q <= state_d;
            ckpt_q  <= (state_q == ST_IDLE) && sec_begin;
            rb_q    <= abort;
            own_q   <= wb_wr && !wb_hit;
            if (wb_wr && !wb_hit) own_addr_q <= req_addr;
            if (in_commit && !drain_last) drain_q <= drain_q + WB_IDX_W'(1);
            else                          drain_q <= '0;
        end
    end

    assign spec_active   = in_spec;
    assign ckpt_req      = ckpt_q;
    assign rollback      = rb_q;
    assign own_req_valid = own_q;
    assign own_req_addr  = own_addr_q;
    assign wr_valid      = in_commit;
    assign wr_addr       = wb_rd_addr;
    assign wr_data       = wb_rd_data;
    assign snp_hold      = in_commit;

    // R2
    ckpt_once_chk: assert property (@(posedge clk) disable iff (rst)
        ckpt_req |=> !ckpt_req);

    // R2
    ckpt_enters_spec_chk: assert property (@(posedge clk) disable iff (rst)
        ckpt_req |-> spec_active);

    // R10
    rollback_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rollback |-> (state_q == ST_IDLE && !ckpt_req));

    // R3
    own_from_spec_chk: assert property (@(posedge clk) disable iff (rst)
        own_req_valid |-> ($past(state_q) == ST_SPEC));

    // R11
    commit_no_spec_chk: assert property (@(posedge clk) disable iff (rst)
        in_commit |=> (state_q != ST_SPEC));

endmodule

// File: tb/elision_monitor_bench.sv
module elision_monitor_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int WD = 4;
    localparam int MD = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sec_begin = 0, sec_end = 0, req_valid = 0, req_is_store = 0, snp_valid = 0;
    logic [AW-1:0] req_addr = '0, snp_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [1:0]    snp_kind = '0;
    logic spec_active, ckpt_req, rollback, own_req_valid, wr_valid, snp_hold;
    logic [AW-1:0] own_req_addr, wr_addr;
    logic [DW-1:0] wr_data;

    always #5 clk = ~clk;

    elision_monitor #(.ADDR_W(AW), .DATA_W(DW), .WB_DEPTH(WD), .MARK_DEPTH(MD)) u_elision_monitor (
        .clk(clk), .rst(rst), .sec_begin(sec_begin), .sec_end(sec_end),
        .req_valid(req_valid), .req_is_store(req_is_store), .req_addr(req_addr),
        .req_data(req_data), .snp_valid(snp_valid), .snp_kind(snp_kind),
        .snp_addr(snp_addr), .spec_active(spec_active), .ckpt_req(ckpt_req),
        .rollback(rollback), .own_req_valid(own_req_valid), .own_req_addr(own_req_addr),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .snp_hold(snp_hold));

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model
    int m_state = 0;          // 0 idle, 1 elision, 2 commit
    int m_drain = 0;
    logic [AW-1:0] m_wb_a[$];
    logic [DW-1:0] m_wb_d[$];
    logic [AW-1:0] m_marks[$];
    bit e_ckpt = 0, e_rb = 0, e_own = 0;
    logic [AW-1:0] e_own_a = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int find_a(input logic [AW-1:0] a, input logic [AW-1:0] q[$]);
        for (int i = 0; i < q.size(); i++) if (q[i] == a) return i;
        return -1;
    endfunction

    task automatic model(input bit beg, input bit en, input bit rv, input bit st,
                         input logic [AW-1:0] ra, input logic [DW-1:0] rd,
                         input int sk, input logic [AW-1:0] sa);
        bit hostile, abort;
        int mi, wi;
        e_ckpt = 0; e_rb = 0; e_own = 0;
        case (m_state)
            0: if (beg) begin m_state = 1; e_ckpt = 1; end
            1: begin
                mi = find_a(ra, m_marks);
                wi = find_a(ra, m_wb_a);
                hostile = (sk >= 2) && (find_a(sa, m_marks) >= 0);
                abort = hostile || (rv && mi < 0 && m_marks.size() >= MD)
                        || (rv && st && wi < 0 && m_wb_a.size() >= WD);
                if (abort) begin
                    m_state = 0; e_rb = 1;
                    m_marks.delete(); m_wb_a.delete(); m_wb_d.delete();
                end else begin
                    if (rv) begin
                        if (mi < 0) m_marks.push_back(ra);
                        if (st) begin
                            if (wi >= 0) m_wb_d[wi] = rd;
                            else begin
                                m_wb_a.push_back(ra); m_wb_d.push_back(rd);
                                e_own = 1; e_own_a = ra;
                            end
                        end
                    end
                    if (en) begin
                        if (m_wb_a.size() == 0) begin m_state = 0; m_marks.delete(); end
                        else begin m_state = 2; m_drain = 0; end
                    end
                end
            end
            default: begin
                m_drain++;
                if (m_drain == m_wb_a.size()) begin
                    m_state = 0; m_drain = 0;
                    m_marks.delete(); m_wb_a.delete(); m_wb_d.delete();
                end
            end
        endcase
    endtask

    task automatic compare();
        chk(spec_active === (m_state == 1), "R2", "spec_active", 64'(spec_active), 64'(m_state == 1));
        chk(ckpt_req === e_ckpt, "R2", "ckpt_req", 64'(ckpt_req), 64'(e_ckpt));
        chk(rollback === e_rb, "R10", "rollback", 64'(rollback), 64'(e_rb));
        chk(own_req_valid === e_own, "R3", "own_req_valid", 64'(own_req_valid), 64'(e_own));
        if (e_own) chk(own_req_addr === e_own_a, "R3", "own_req_addr", 64'(own_req_addr), 64'(e_own_a));
        chk(wr_valid === (m_state == 2), "R11", "wr_valid", 64'(wr_valid), 64'(m_state == 2));
        chk(snp_hold === (m_state == 2), "R11", "snp_hold", 64'(snp_hold), 64'(m_state == 2));
        if (m_state == 2) begin
            chk(wr_addr === m_wb_a[m_drain], "R11", "wr_addr", 64'(wr_addr), 64'(m_wb_a[m_drain]));
            chk(wr_data === m_wb_d[m_drain], "R4", "wr_data", 64'(wr_data), 64'(m_wb_d[m_drain]));
        end
    endtask

    task automatic step(input bit beg, input bit en, input bit rv, input bit st,
                        input logic [AW-1:0] ra, input logic [DW-1:0] rd,
                        input int sk, input logic [AW-1:0] sa);
        sec_begin = beg; sec_end = en; req_valid = rv; req_is_store = st;
        req_addr = ra; req_data = rd; snp_valid = (sk != 0); snp_kind = 2'(sk); snp_addr = sa;
        @(posedge clk);
        model(beg, en, rv, st, ra, rd, sk, sa);
        #2;
        compare();
    endtask

    task automatic idle(); step(0, 0, 0, 0, '0, '0, 0, '0); endtask
    task automatic beg(); step(1, 0, 0, 0, '0, '0, 0, '0); endtask
    task automatic fin(); step(0, 1, 0, 0, '0, '0, 0, '0); endtask
    task automatic ld(input logic [AW-1:0] a); step(0, 0, 1, 0, a, '0, 0, '0); endtask
    task automatic sto(input logic [AW-1:0] a, input logic [DW-1:0] d); step(0, 0, 1, 1, a, d, 0, '0); endtask
    task automatic snp(input int k, input logic [AW-1:0] a); step(0, 0, 0, 0, '0, '0, k, a); endtask
    task automatic drain(); repeat (WD + 2) idle(); endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk(!spec_active && !ckpt_req && !rollback && !own_req_valid && !wr_valid && !snp_hold,
            "R1", "outputs after reset", {58'd0, spec_active, ckpt_req, rollback, own_req_valid, wr_valid, snp_hold}, 64'd0);
        rst = 0;
        idle();

        // R13: idle store, end and snoop are ignored
        sto(16'h00A0, 32'h11); fin(); snp(2, 16'h00A0);
        beg(); snp(2, 16'h00A0); snp(3, 16'h00A0); fin(); idle();

        // R2 R3 R4 R7 R11: buffered section, merge, nested begin ignored, drain with held snoops
        beg();
        sto(16'h0100, 32'hA1); ld(16'h0200); beg();
        sto(16'h0300, 32'hA2);
        step(0, 0, 1, 1, 16'h0100, 32'hA3, 1, 16'h0100); // R4 merge, R7 read snoop
        snp(2, 16'h0777);                                 // R7 unmarked
        sto(16'h0400, 32'hA4);
        fin();
        snp(2, 16'h0100); snp(3, 16'h0300); drain();

        // R5 R10 R12: invalidate abort, fresh section afterwards
        beg(); ld(16'h0500); sto(16'h0510, 32'hB1); snp(2, 16'h0500);
        idle(); beg(); snp(2, 16'h0500); fin(); idle();

        // R6: exclusive request hits a store-marked block; end in same cycle loses to abort
        beg(); sto(16'h0600, 32'hC1); snp(3, 16'h0601);
        step(0, 1, 0, 0, '0, '0, 3, 16'h0600); idle(); idle();

        // R8: buffer exhaustion
        beg();
        for (int i = 0; i < WD; i++) sto(16'h0700 + 16'(i), 32'hD0 + 32'(i));
        sto(16'h0701, 32'hDF);            // merge while full
        sto(16'h07F0, 32'hEE);            // needs a new slot
        idle();
        beg(); sto(16'h0800, 32'hE1); fin(); drain(); // R10 old stores gone

        // R9: mark table exhaustion
        beg();
        for (int i = 0; i < MD; i++) ld(16'h0900 + 16'(i));
        ld(16'h0903); sto(16'h0900, 32'hF1);
        ld(16'h09F0);
        idle();

        // R11: store in the same cycle as the end marker
        beg(); step(0, 1, 1, 1, 16'h0A00, 32'h77, 0, '0); drain();
        idle();
        summary();
    end
endmodule